// File: doc/BRIEF.md
# Remote DMA Data-Port Engine

This block gives a host processor a single data port through which it moves data into and out of a local buffer memory, one access at a time. The host first loads a 16-bit remote address and a 16-bit remote byte count through byte-wide register writes. Each data-port read or write then touches local memory at the current address. After the access the address steps forward and the count steps down. When the count runs out, a completion status bit is raised.

The address steps by 1, 2 or 4 bytes. The step depends on a data-width configuration bit and on whether the access is 32 bits wide. When the address reaches the end of a programmable receive ring, it jumps back to the ring's first page. The local memory holds two windows that accept accesses: a 32-byte identity area at address zero and a packet area. Every other address reads as all ones and drops writes.

The block also holds the interrupt status and mask registers. Neighbouring framing logic can raise status bits 5:0. Software clears status bits by writing ones. A combinational interrupt line follows any unmasked status bit in 6:0.

Top module: `rdma_port_engine`

## Requirements
- R1: Register offsets are 0 command, 1 ring first page, 2 ring end page, 3 mask, 4 status, 5 config, 6/7 address low/high, 8/9 count low/high. Every offset reads back its register, and other offsets read 0. Writing one byte of the address or the count leaves the other byte unchanged.
- R2: Each data-port access moves the address forward by a step. The step is 4 when `portWide` is high. Otherwise it is 2 when config bit 0 is 1, and 1 when config bit 0 is 0.
- R3: If the stepped address equals the ring end page times 256, the address becomes the ring first page times 256. This applies to reads and writes.
- R4: If the count is less than or equal to the step, an access sets the count to 0 and sets status bit 6. Otherwise the access subtracts the step from the count.
- R5: A data-port write while the count is 0 changes neither memory, address, count nor status bit 6.
- R6: A command write with bit 0 clear, with bit 3 or bit 4 set, and with the count at 0 sets status bit 6 at once.
- R7: Writing the status register clears each bit 6:0 written as 1, and never touches bit 7. A set request in the same cycle wins over a clear.
- R8: `irq` is high exactly when some bit 6:0 is set in both status and mask. Status bit 7 never raises it.
- R9: After reset, status reads 0x80, command reads 0x01, the ring pages are the packet-area bounds (0x40 and 0x44 by default), and mask, config, address and count read 0. A command write with bit 0 clear clears status bit 7. Bit 7 is set again only by reset.
- R10: 16- and 32-bit accesses ignore address bit 0 and store and return bytes little-endian (lowest address in bits 7:0).
- R11: Each byte lane that falls outside both the identity area (0x0000–0x001F) and the packet area (0x4000–0x43FF by default) reads 0xFF and ignores writes.
- R12: A ring page write is ignored if the page times 256 exceeds the end of the packet area.
- R13: A one-cycle pulse on `evtSet` bit n sets status bit n, for n from 0 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register offset |
| regWdata | input | 8 | Register write byte |
| regRdata | output | 8 | Register read byte (combinational) |
| portRe | input | 1 | Data-port read strobe |
| portWe | input | 1 | Data-port write strobe |
| portWide | input | 1 | Access is 32 bits wide |
| portWdata | input | 32 | Data-port write value |
| portRdata | output | 32 | Data-port read value at the current address |
| evtSet | input | 6 | Status set pulses from framing logic |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches every cycle for the following:
- address stepping and ring wrap against the step the config and width select;
- count decrement and completion on the last beat;
- address and count staying frozen when a write arrives at count 0;
- the reset flag never rising again;
- the interrupt staying low when only bit 7 matches.

Several behaviours need the bench scenarios, which store and read back data:
- little-endian byte order and the ignored address bit 0;
- the all-ones response outside the two memory windows;
- the register byte merges and the rejected ring pages;
- the zero-length command;
- set-over-clear ordering on the status register.

// File: rtl/rdma_pkg.sv
`timescale 1ns/1ps
package rdma_pkg;
  typedef enum logic [3:0] {
    OFF_CMD        = 4'd0,
    OFF_RING_FIRST = 4'd1,
    OFF_RING_END   = 4'd2,
    OFF_MASK       = 4'd3,
    OFF_STATUS     = 4'd4,
    OFF_CFG        = 4'd5,
    OFF_ADDR_LO    = 4'd6,
    OFF_ADDR_HI    = 4'd7,
    OFF_CNT_LO     = 4'd8,
    OFF_CNT_HI     = 4'd9
  } regOff_e;

  localparam int CMD_HALT_BIT = 0;
  localparam int CMD_RD_BIT   = 3;
  localparam int CMD_WR_BIT   = 4;
  localparam int ST_DONE_BIT  = 6;
  localparam int ST_RST_BIT   = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic       ldAddrLo;
    logic       ldAddrHi;
    logic       ldCntLo;
    logic       ldCntHi;
    logic       advance;
    logic [2:0] step;
    logic [7:0] regByte;
  } rdmaStrobe_t;
endpackage

// File: rtl/rdma_localmem.sv
`timescale 1ns/1ps
module rdma_localmem #(
  parameter int AW         = 16,
  parameter int PROM_BYTES = 32,
  parameter int PKT_BASE   = 16'h4000,
  parameter int PKT_BYTES  = 1024,
  parameter int LANES      = 4
) (
  input  logic                 clk,
  input  logic                 wrEn,
  input  logic [AW-1:0]        base,
  input  logic [LANES-1:0]     laneMask,
  input  logic [8*LANES-1:0]   wdata,
  output logic [8*LANES-1:0]   rdata
);
  localparam int DEPTH   = PROM_BYTES + PKT_BYTES;
  localparam int IW      = $clog2(DEPTH);
  localparam int PKT_END = PKT_BASE + PKT_BYTES;

  logic [7:0] store [DEPTH];

  function automatic logic inWindow(input logic [AW-1:0] a);
    return (int'(a) < PROM_BYTES) || (int'(a) >= PKT_BASE && int'(a) < PKT_END);
  endfunction

  function automatic logic [IW-1:0] slotOf(input logic [AW-1:0] a);
    if (int'(a) < PROM_BYTES) return IW'(int'(a));
    return IW'(int'(a) - PKT_BASE + PROM_BYTES);
  endfunction

  logic [AW-1:0] laneAddr [LANES];
  logic [IW-1:0] laneIdx  [LANES];
  logic          laneOk   [LANES];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneAddr[g] = base + AW'(g);
    assign laneOk[g]   = inWindow(laneAddr[g]);
    assign laneIdx[g]  = slotOf(laneAddr[g]);
    assign rdata[8*g +: 8] = !laneMask[g] ? 8'h00 :
                             (laneOk[g] ? store[laneIdx[g]] : 8'hFF);
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wrEn && laneMask[l] && laneOk[l]) store[laneIdx[l]] <= wdata[8*l +: 8];
    end
  end
endmodule

// File: rtl/rdma_datapath.sv
`timescale 1ns/1ps
module rdma_datapath import rdma_pkg::*; #(
  parameter int PAGE_W = 8,
  parameter int CW     = 16,
  parameter int LANES  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  rdmaStrobe_t         strobe,
  input  logic [PAGE_W-1:0]   startPage,
  input  logic [PAGE_W-1:0]   stopPage,
  output logic [PAGE_W+7:0]   addrQ,
  output logic [CW-1:0]       cntQ,
  output logic                cntZero,
  output logic                lastBeat,
  output logic [PAGE_W+7:0]   memBase,
  output logic [LANES-1:0]    laneMask
);
  localparam int AW = PAGE_W + 8;

  logic [AW-1:0] addrStep, addrNext, stopAddr, startAddr;
  logic [CW-1:0] stepCnt;

  assign stepCnt   = CW'(strobe.step);
  assign cntZero   = (cntQ == '0);
  assign lastBeat  = strobe.advance && (cntQ <= stepCnt);
  assign stopAddr  = {stopPage, 8'h00};
  assign startAddr = {startPage, 8'h00};
  assign addrStep  = addrQ + AW'(strobe.step);
  assign addrNext  = (addrStep == stopAddr) ? startAddr : addrStep;

  // wide accesses drop address bit 0
  assign memBase = (strobe.step == 3'd1) ? addrQ : {addrQ[AW-1:1], 1'b0};

  always_comb begin
    unique case (strobe.step)
      3'd4:    laneMask = LANES'(4'b1111);
      3'd2:    laneMask = LANES'(4'b0011);
      default: laneMask = LANES'(4'b0001);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (strobe.ldAddrLo) begin
      addrQ[7:0] <= strobe.regByte;
    end else if (strobe.ldAddrHi) begin
      addrQ[AW-1:8] <= PAGE_W'(strobe.regByte);
    end else if (strobe.advance) begin
      addrQ <= addrNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.ldCntLo) begin
      cntQ[7:0] <= strobe.regByte;
    end else if (strobe.ldCntHi) begin
      cntQ[CW-1:8] <= (CW-8)'(strobe.regByte);
    end else if (strobe.advance) begin
      cntQ <= lastBeat ? '0 : cntQ - stepCnt;
    end
  end
endmodule

// File: rtl/rdma_ctrl.sv
`timescale 1ns/1ps
module rdma_ctrl import rdma_pkg::*; #(
  parameter int PAGE_W    = 8,
  parameter int CW        = 16,
  parameter int PKT_BASE  = 16'h4000,
  parameter int PKT_BYTES = 1024,
  parameter int EVT_W     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              portRe,
  input  logic              portWe,
  input  logic              portWide,
  input  logic [EVT_W-1:0]  evtSet,
  input  logic [PAGE_W+7:0] addrQ,
  input  logic [CW-1:0]     cntQ,
  input  logic              cntZero,
  input  logic              lastBeat,
  output rdmaStrobe_t       strobe,
  output logic              memWr,
  output logic [7:0]        cmdQ,
  output logic [PAGE_W-1:0] startPage,
  output logic [PAGE_W-1:0] stopPage,
  output logic [7:0]        imrQ,
  output logic [7:0]        isrQ,
  output logic [7:0]        cfgQ,
  output logic              irq
);
  localparam int END_PAGE  = (PKT_BASE + PKT_BYTES) / 256;
  localparam int BASE_PAGE = PKT_BASE / 256;

  regOff_e off;
  logic    cmdWr, pageOk, zeroLen;
  logic [7:0] isrNext;

  assign off    = regOff_e'(regAddr);
  assign cmdWr  = regWe && (off == OFF_CMD);
  assign pageOk = int'(regWdata) <= END_PAGE;
  assign zeroLen = cmdWr && !regWdata[CMD_HALT_BIT] &&
                   (regWdata[CMD_RD_BIT] || regWdata[CMD_WR_BIT]) && cntZero;

  assign memWr = portWe && !cntZero;

  always_comb begin
    strobe          = '0;
    strobe.regByte  = regWdata;
    strobe.ldAddrLo = regWe && (off == OFF_ADDR_LO);
    strobe.ldAddrHi = regWe && (off == OFF_ADDR_HI);
    strobe.ldCntLo  = regWe && (off == OFF_CNT_LO);
    strobe.ldCntHi  = regWe && (off == OFF_CNT_HI);
    strobe.advance  = portRe || memWr;
    strobe.step     = portWide ? 3'd4 : (cfgQ[0] ? 3'd2 : 3'd1);
  end

  // clears first, sets last: a set wins
  always_comb begin
    isrNext = isrQ;
    if (regWe && off == OFF_STATUS) isrNext[6:0] = isrQ[6:0] & ~regWdata[6:0];
    if (cmdWr && !regWdata[CMD_HALT_BIT]) isrNext[ST_RST_BIT] = 1'b0;
    isrNext[EVT_W-1:0] = isrNext[EVT_W-1:0] | evtSet;
    if (lastBeat || zeroLen) isrNext[ST_DONE_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ      <= 8'h01;
      startPage <= PAGE_W'(BASE_PAGE);
      stopPage  <= PAGE_W'(END_PAGE);
      imrQ      <= 8'h00;
      isrQ      <= 8'h80;
      cfgQ      <= 8'h00;
    end else begin
      isrQ <= isrNext;
      if (regWe) begin
        unique case (off)
          OFF_CMD:        cmdQ <= regWdata;
          OFF_RING_FIRST: if (pageOk) startPage <= PAGE_W'(regWdata);
          OFF_RING_END:   if (pageOk) stopPage  <= PAGE_W'(regWdata);
          OFF_MASK:       imrQ <= regWdata;
          OFF_CFG:        cfgQ <= regWdata;
          default: ;
        endcase
      end
    end
  end

  assign irq = |(isrQ[6:0] & imrQ[6:0]);

  always_comb begin
    unique case (off)
      OFF_CMD:        regRdata = cmdQ;
      OFF_RING_FIRST: regRdata = 8'(startPage);
      OFF_RING_END:   regRdata = 8'(stopPage);
      OFF_MASK:       regRdata = imrQ;
      OFF_STATUS:     regRdata = isrQ;
      OFF_CFG:        regRdata = cfgQ;
      OFF_ADDR_LO:    regRdata = addrQ[7:0];
      OFF_ADDR_HI:    regRdata = 8'(addrQ[PAGE_W+7:8]);
      OFF_CNT_LO:     regRdata = cntQ[7:0];
      OFF_CNT_HI:     regRdata = 8'(cntQ[CW-1:8]);
      default:        regRdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rdma_port_engine.sv
`timescale 1ns/1ps
module rdma_port_engine import rdma_pkg::*; #(
  parameter int PAGE_W     = 8,
  parameter int CW         = 16,
  parameter int PROM_BYTES = 32,
  parameter int PKT_BASE   = 16'h4000,
  parameter int PKT_BYTES  = 1024,
  parameter int EVT_W      = 6,
  parameter int LANES      = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [3:0]         regAddr,
  input  logic [7:0]         regWdata,
  output logic [7:0]         regRdata,
  input  logic               portRe,
  input  logic               portWe,
  input  logic               portWide,
  input  logic [8*LANES-1:0] portWdata,
  output logic [8*LANES-1:0] portRdata,
  input  logic [EVT_W-1:0]   evtSet,
  output logic               irq
);
  localparam int AW = PAGE_W + 8;

  rdmaStrobe_t       strobe;
  logic              memWr, cntZero, lastBeat;
  logic [AW-1:0]     addrQ, memBase;
  logic [CW-1:0]     cntQ;
  logic [LANES-1:0]  laneMask;
  logic [7:0]        cmdQ, imrQ, isrQ, cfgQ;
  logic [PAGE_W-1:0] startPage, stopPage;

  rdma_ctrl #(.PAGE_W(PAGE_W), .CW(CW), .PKT_BASE(PKT_BASE),
              .PKT_BYTES(PKT_BYTES), .EVT_W(EVT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .portRe(portRe),
    .portWe(portWe), .portWide(portWide), .evtSet(evtSet),
    .addrQ(addrQ), .cntQ(cntQ), .cntZero(cntZero), .lastBeat(lastBeat),
    .strobe(strobe), .memWr(memWr), .cmdQ(cmdQ), .startPage(startPage),
    .stopPage(stopPage), .imrQ(imrQ), .isrQ(isrQ), .cfgQ(cfgQ), .irq(irq)
  );

  rdma_datapath #(.PAGE_W(PAGE_W), .CW(CW), .LANES(LANES)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startPage(startPage),
    .stopPage(stopPage), .addrQ(addrQ), .cntQ(cntQ), .cntZero(cntZero),
    .lastBeat(lastBeat), .memBase(memBase), .laneMask(laneMask)
  );

  rdma_localmem #(.AW(AW), .PROM_BYTES(PROM_BYTES), .PKT_BASE(PKT_BASE),
                  .PKT_BYTES(PKT_BYTES), .LANES(LANES)) uMem (
    .clk(clk), .wrEn(memWr), .base(memBase), .laneMask(laneMask),
    .wdata(portWdata), .rdata(portRdata)
  );
endmodule

// File: rtl/rdma_port_engine_checks.sv
`timescale 1ns/1ps
module rdma_port_engine_checks #(
  parameter int AW     = 16,
  parameter int PAGE_W = 8,
  parameter int CW     = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic              portRe,
  input logic              portWe,
  input logic              portWide,
  input logic              irq,
  input logic [AW-1:0]     addrQ,
  input logic [CW-1:0]     cntQ,
  input logic [7:0]        isrQ,
  input logic [7:0]        imrQ,
  input logic [7:0]        cfgQ,
  input logic [PAGE_W-1:0] startPage,
  input logic [PAGE_W-1:0] stopPage
);
  logic [AW-1:0] stepA, stopA;
  logic          advC;
  assign stepA = portWide ? AW'(4) : (cfgQ[0] ? AW'(2) : AW'(1));
  assign stopA = {stopPage, 8'h00};
  assign advC  = !regWe && (portRe || (portWe && cntQ != '0));

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (advC && (addrQ + stepA) != stopA) |=> addrQ == $past(addrQ + stepA)); // R2
  AST_RING_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (advC && (addrQ + stepA) == stopA) |=> addrQ == {$past(startPage), 8'h00}); // R3
  AST_LAST_BEAT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (advC && CW'(stepA) >= cntQ) |=> (cntQ == '0 && isrQ[6])); // R4
  AST_WRITE_AT_ZERO_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (portWe && !portRe && !regWe && cntQ == '0) |=> ($stable(cntQ) && $stable(addrQ))); // R5
  AST_BIT7_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    ((isrQ[6:0] & imrQ[6:0]) == 7'd0) |-> !irq); // R8
  AST_RESET_FLAG_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    !isrQ[7] |=> !isrQ[7]); // R9
endmodule

bind rdma_port_engine rdma_port_engine_checks #(.AW(AW), .PAGE_W(PAGE_W), .CW(CW)) chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .portRe(portRe), .portWe(portWe),
  .portWide(portWide), .irq(irq), .addrQ(addrQ), .cntQ(cntQ), .isrQ(isrQ),
  .imrQ(imrQ), .cfgQ(cfgQ), .startPage(startPage), .stopPage(stopPage)
);

// File: tb/rdma_port_engine_test.sv
`timescale 1ns/1ps
module rdma_port_engine_test;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWe = 0, portRe = 0, portWe = 0, portWide = 0;
  logic [3:0]  regAddr = 0;
  logic [7:0]  regWdata = 0, regRdata;
  logic [31:0] portWdata = 0, portRdata;
  logic [5:0]  evtSet = 0;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #(CLK_P/2) clk = ~clk;

  rdma_port_engine uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .portRe(portRe),
    .portWe(portWe), .portWide(portWide), .portWdata(portWdata),
    .portRdata(portRdata), .evtSet(evtSet), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every data-port read
  always @(negedge clk) begin
    if (portRe) begin
      if (expQ.size() == 0) check("scoreboard-empty", 32'h1, 32'h0);
      else check(tagQ.pop_front(), portRdata, expQ.pop_front());
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual hung expected done");
    finishRun();
  end

  // all tasks start and end 2 ns after a rising edge
  task automatic regWr(input logic [3:0] a, input logic [7:0] d);
    regWe = 1; regAddr = a; regWdata = d;
    @(posedge clk); #2;
    regWe = 0;
  endtask

  task automatic expectReg(input string tag, input logic [3:0] a, input logic [7:0] exp);
    regAddr = a;
    @(negedge clk);
    check(tag, {24'h0, regRdata}, {24'h0, exp});
    @(posedge clk); #2;
  endtask

  task automatic expectIrq(input string tag, input logic exp);
    @(negedge clk);
    check(tag, {31'h0, irq}, {31'h0, exp});
    @(posedge clk); #2;
  endtask

  task automatic setAddr(input logic [15:0] a);
    regWr(4'd6, a[7:0]); regWr(4'd7, a[15:8]);
  endtask

  task automatic setCnt(input logic [15:0] c);
    regWr(4'd8, c[7:0]); regWr(4'd9, c[15:8]);
  endtask

  task automatic portWr(input logic wide, input logic [31:0] d);
    portWe = 1; portWide = wide; portWdata = d;
    @(posedge clk); #2;
    portWe = 0; portWide = 0;
  endtask

  // driver: pushes the expected value, the monitor compares it
  task automatic portRd(input string tag, input logic wide, input logic [31:0] exp);
    expQ.push_back(exp); tagQ.push_back(tag);
    portRe = 1; portWide = wide;
    @(posedge clk); #2;
    portRe = 0; portWide = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    @(posedge clk); #2;

    // R9 reset state
    expectReg("R9 status", 4'd4, 8'h80);
    expectReg("R9 command", 4'd0, 8'h01);
    expectReg("R9 first page", 4'd1, 8'h40);
    expectReg("R9 end page", 4'd2, 8'h44);
    expectReg("R9 count", 4'd8, 8'h00);
    expectReg("R1 unused offset", 4'd12, 8'h00);
    // R7 bit 7 untouched by status write; R8 bit 7 never drives irq
    regWr(4'd4, 8'hFF);
    expectReg("R7 bit7 kept", 4'd4, 8'h80);
    regWr(4'd3, 8'hFF);
    expectIrq("R8 bit7 silent", 1'b0);
    regWr(4'd3, 8'h00);
    regWr(4'd0, 8'h22);
    expectReg("R9 start clears bit7", 4'd4, 8'h00);

    // R6 zero-length command
    regWr(4'd0, 8'h0A);
    expectReg("R6 read zero len", 4'd4, 8'h40);
    regWr(4'd4, 8'h40);
    regWr(4'd0, 8'h09);
    expectReg("R6 halted no done", 4'd4, 8'h00);
    regWr(4'd0, 8'h02);
    expectReg("R6 no dma bit", 4'd4, 8'h00);
    regWr(4'd0, 8'h12);
    expectReg("R6 write zero len", 4'd4, 8'h40);
    regWr(4'd4, 8'h40);

    // R1 byte merges
    setAddr(16'h1234);
    expectReg("R1 addr lo", 4'd6, 8'h34);
    regWr(4'd6, 8'h56);
    expectReg("R1 addr hi kept", 4'd7, 8'h12);
    setCnt(16'h0203);
    regWr(4'd9, 8'h00);
    expectReg("R1 cnt lo kept", 4'd8, 8'h03);

    // R4 byte writes, count and completion
    setAddr(16'h4000);
    portWr(0, 32'hAA); portWr(0, 32'hBB);
    expectReg("R4 count 1", 4'd8, 8'h01);
    expectReg("R4 not done", 4'd4, 8'h00);
    portWr(0, 32'hCC);
    expectReg("R4 count 0", 4'd8, 8'h00);
    expectReg("R4 done set", 4'd4, 8'h40);
    expectReg("R2 addr step 1", 4'd6, 8'h03);
    regWr(4'd3, 8'h40);
    expectIrq("R8 irq on done", 1'b1);
    regWr(4'd4, 8'h40);
    expectIrq("R8 irq cleared", 1'b0);
    regWr(4'd3, 8'h00);

    // R5 write ignored at zero count
    setAddr(16'h4002);
    portWr(0, 32'h11);
    expectReg("R5 addr frozen", 4'd6, 8'h02);
    expectReg("R5 no done", 4'd4, 8'h00);
    setCnt(16'h0001);
    portRd("R5 memory kept", 0, 32'hCC);
    regWr(4'd4, 8'h40);

    // R2 / R10 16-bit mode, odd start address
    regWr(4'd5, 8'h01);
    setAddr(16'h4011); setCnt(16'h0004);
    portWr(0, 32'hBEEF); portWr(0, 32'h1234);
    expectReg("R2 addr step 2", 4'd6, 8'h15);
    expectReg("R4 done 16", 4'd4, 8'h40);
    regWr(4'd4, 8'h40);
    regWr(4'd5, 8'h00);
    setAddr(16'h4010); setCnt(16'h0004);
    portRd("R10 byte0", 0, 32'hEF); portRd("R10 byte1", 0, 32'hBE);
    portRd("R10 byte2", 0, 32'h34); portRd("R10 byte3", 0, 32'h12);
    regWr(4'd5, 8'h01);
    setAddr(16'h4013); setCnt(16'h0002);
    portRd("R10 odd half read", 0, 32'h1234);
    regWr(4'd5, 8'h00);

    // R2 32-bit
    setAddr(16'h4020); setCnt(16'h0006);
    portWr(1, 32'hDEADBEEF);
    expectReg("R4 count minus 4", 4'd8, 8'h02);
    portWr(1, 32'h01020304);
    expectReg("R4 count 0 wide", 4'd8, 8'h00);
    expectReg("R2 addr step 4", 4'd6, 8'h28);
    setAddr(16'h4020); setCnt(16'h0008);
    portRd("R2 wide read 0", 1, 32'hDEADBEEF);
    portRd("R2 wide read 1", 1, 32'h01020304);
    setAddr(16'h4024); setCnt(16'h0001);
    portRd("R10 little endian", 0, 32'h04);
    regWr(4'd4, 8'h40);

    // R3 wrap
    regWr(4'd1, 8'h41); regWr(4'd2, 8'h42);
    setAddr(16'h41FF); setCnt(16'h0002);
    portWr(0, 32'h5A); portWr(0, 32'h6B);
    expectReg("R3 wrap hi", 4'd7, 8'h41);
    expectReg("R3 wrap lo", 4'd6, 8'h01);
    setAddr(16'h41FF); setCnt(16'h0002);
    portRd("R3 read before wrap", 0, 32'h5A);
    portRd("R3 read after wrap", 0, 32'h6B);

    // R12 ring page limits
    regWr(4'd2, 8'h50);
    expectReg("R12 end rejected", 4'd2, 8'h42);
    regWr(4'd1, 8'h45);
    expectReg("R12 first rejected", 4'd1, 8'h41);
    regWr(4'd2, 8'h44);
    expectReg("R12 end at limit", 4'd2, 8'h44);

    // R11 windows
    setAddr(16'h0100); setCnt(16'h0001);
    portRd("R11 hole reads ones", 0, 32'hFF);
    setAddr(16'h3FFF); setCnt(16'h0001);
    portWr(0, 32'h77);
    setAddr(16'h3FFF); setCnt(16'h0001);
    portRd("R11 hole write dropped", 0, 32'hFF);
    setAddr(16'h0005); setCnt(16'h0001);
    portWr(0, 32'h42);
    setAddr(16'h0005); setCnt(16'h0001);
    portRd("R11 identity area", 0, 32'h42);
    setAddr(16'h001E); setCnt(16'h0002);
    portWr(0, 32'h11); portWr(0, 32'h22);
    setAddr(16'h001E); setCnt(16'h0004);
    portRd("R11 partial lanes", 1, 32'hFFFF2211);

    // R13 event sets, R7 clear and set-wins
    regWr(4'd4, 8'h7F);
    evtSet = 6'h05;
    @(posedge clk); #2;
    evtSet = 6'h00;
    expectReg("R13 events", 4'd4, 8'h05);
    regWr(4'd3, 8'h04);
    expectIrq("R8 event irq", 1'b1);
    regWr(4'd4, 8'h04);
    expectReg("R7 clear one", 4'd4, 8'h01);
    expectIrq("R8 masked off", 1'b0);
    regWe = 1; regAddr = 4'd4; regWdata = 8'h01; evtSet = 6'h01;
    @(posedge clk); #2;
    regWe = 0; evtSet = 6'h00;
    expectReg("R7 set wins", 4'd4, 8'h01);

    repeat (2) @(posedge clk);
    check("scoreboard drained", expQ.size(), 0);
    finishRun();
  end
endmodule